// File: doc/BRIEF.md
# Uncached Store Bus Splitter

This block sits between a store buffer and the bus interface. It takes one uncached or write-protected store at a time. Each store has a byte address, a byte count and up to sixteen bytes of data. The block turns the store into qword-wide bus write beats. Each beat carries a qword address, an 8-bit byte-enable mask, 64 bits of lane-aligned data, the beat count of its transaction, and a last-beat marker.

The output depends on where the store lies:

- A store that fits inside one qword leaves as one single-beat write.
- A store that spills over a qword boundary leaves as two independent single-beat writes, lower address first.
- A 16-byte store on a 16-byte boundary leaves as one two-beat transaction in toggle order.
- A 16-byte store that is not on a 16-byte boundary is refused with an error pulse. So is any store with an unsupported byte count.

The store side accepts nothing new until every beat of the current store has been taken by the bus side.

Top module: `ucst_splitter`

## Requirements
- R1: A store of 1 to 8 bytes that lies inside one qword produces exactly one write. That write has `bus_beats`=1 and `bus_last`=1, and `bus_qaddr` equals the byte address shifted right by 3. Byte-enable bit i is set exactly for the lanes from the address offset (address bits [2:0]) up to offset+size-1.
- R2: Store data byte j is placed on bus lane (address+j) mod 8, that is, `bus_data` bits [8*lane+7 : 8*lane]. The lane sits in the first or second write according to which qword holds byte address+j. Lanes whose enable bit is clear carry zero.
- R3: A store of 2 to 8 bytes that crosses a qword boundary produces two writes, each with `bus_beats`=1 and `bus_last`=1. The first write is to the lower qword, with enables from the offset up to lane 7. The second write is to the next qword address (modulo the address space), with enables from lane 0 up to the last written byte.
- R4: An 8-byte store with address bits [2:0]=0 produces one single-beat write with `bus_be`=8'hFF.
- R5: A 16-byte store with address bits [3:0]=0 produces one transaction of two beats. Both beats show `bus_beats`=2 and `bus_be`=8'hFF. Beat k goes to qword address (base qword) XOR k and carries store bytes 8k..8k+7. `bus_last` is 0 on beat 0 and 1 on beat 1.
- R6: Out of reset, `st_ready`=1 and `bus_valid`=0. After a store is accepted, `st_ready` stays 0 until the bus has accepted the last beat of that store. `bus_valid` is 1 exactly while beats of an accepted store remain outstanding.
- R7: While `bus_valid`=1 and `bus_ready`=0, the beat's address, enables, data, beat count and last marker hold unchanged into the next cycle.
- R8: A store is rejected in the cycle it is accepted if its size is 16 with address bits [3:0] not zero, or if its size is 0, 9 to 15, or above 16. For a rejected store, `st_err` is 1 in that cycle and no bus write is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Splitter can take a store |
| st_addr | input | AW | Byte address of the store |
| st_size | input | 5 | Byte count: 1..8 or 16 |
| st_data | input | 128 | Store data, byte j in bits [8j+7:8j] |
| st_err | output | 1 | Store accepted but rejected as illegal |
| bus_valid | output | 1 | Bus write beat present |
| bus_ready | input | 1 | Bus takes the beat |
| bus_qaddr | output | AW-3 | Qword address of the beat |
| bus_be | output | 8 | Byte enables of the beat |
| bus_data | output | 64 | Lane-aligned beat data |
| bus_beats | output | 2 | Beats in this transaction (1 or 2) |
| bus_last | output | 1 | Final beat of its transaction |

## Verification
The bench builds the splitter with AW=16. With this width, stores aimed at the very top of the address space can be reached directly. A crossing store at address 16'hFFFC must wrap its second write to qword 0, and a 16-byte store at 16'hFFF0 occupies the last two qwords. Random bus back-pressure exercises the stall hold rule on both beats of the toggle burst and on the second half of split stores. Every offset from 0 to 7 is driven with every legal size.

// File: rtl/ucst_pkg.sv
// Shared constants and types for the uncached store splitter.
// Assumes qword-wide bus beats and stores of at most two qwords.
package ucst_pkg;
    localparam int QW_BYTES  = 8;
    localparam int MAX_BYTES = 2 * QW_BYTES;
    localparam int SIZE_W    = 5;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FIRST  = 2'd1,
        SQ_SECOND = 2'd2
    } sq_state_e;
endpackage

// File: rtl/ucst_lane_shift.sv
// Places store bytes onto a two-qword lane window, starting at the
// byte offset inside the first qword, and marks the lanes written.
// Assumes size <= MAX_BYTES; lanes past the window are dropped.
module ucst_lane_shift
    import ucst_pkg::*;
(
    input  logic [2:0]               off,
    input  logic [SIZE_W-1:0]        size,
    input  logic [MAX_BYTES*8-1:0]   data,
    output logic [MAX_BYTES-1:0]     mask,
    output logic [MAX_BYTES*8-1:0]   lanes
);
    localparam int IDX_W = $clog2(MAX_BYTES);

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
        logic [IDX_W-1:0] idx;
        logic             hit;
        // source byte index feeding lane i
        assign idx = IDX_W'(i) - IDX_W'(off);
        // lane i is written when it is at or past the offset and inside the size
        assign hit = (IDX_W'(i) >= IDX_W'(off)) && ({1'b0, idx} < size);
        assign mask[i] = hit;
        assign lanes[i*8 +: 8] = hit ? data[idx*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/ucst_decode.sv
// Classifies a store and builds the byte enables and data of its
// lower and upper qword. Purely combinational.
// Assumes the caller only uses the result when bad is low.
module ucst_decode
    import ucst_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]            addr,
    input  logic [SIZE_W-1:0]        size,
    input  logic [MAX_BYTES*8-1:0]   data,
    output logic                     bad,
    output logic                     burst,
    output logic                     two,
    output logic [QW_BYTES-1:0]      be_lo,
    output logic [QW_BYTES-1:0]      be_hi,
    output logic [QW_BYTES*8-1:0]    d_lo,
    output logic [QW_BYTES*8-1:0]    d_hi
);
    logic [MAX_BYTES-1:0]   mask;
    logic [MAX_BYTES*8-1:0] lanes;
    logic                   small_ok;
    logic                   big_ok;

    ucst_lane_shift u_shift (
        .off   (addr[2:0]),
        .size  (size),
        .data  (data),
        .mask  (mask),
        .lanes (lanes)
    );

    // legality: 1..8 bytes anywhere, or 16 bytes on a 16-byte boundary
    always_comb begin
        small_ok = (size >= SIZE_W'(1)) && (size <= SIZE_W'(QW_BYTES));
        big_ok   = (size == SIZE_W'(MAX_BYTES)) && (addr[3:0] == 4'h0);
        bad      = !(small_ok || big_ok);
        burst    = big_ok;
    end

    // split the lane window into the lower and upper qword
    always_comb begin
        be_lo = mask[QW_BYTES-1:0];
        be_hi = mask[MAX_BYTES-1:QW_BYTES];
        d_lo  = lanes[QW_BYTES*8-1:0];
        d_hi  = lanes[MAX_BYTES*8-1:QW_BYTES*8];
        two   = |be_hi;
    end
endmodule

// File: rtl/ucst_sequencer.sv
// Holds one decoded store and issues its beats on the bus stream.
// A crossing store becomes two single-beat writes; an aligned
// 16-byte store becomes one two-beat write in toggle order.
// Assumes accept is only raised while st_ready is high.
module ucst_sequencer
    import ucst_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept,
    input  logic [AW-1:0]          addr,
    input  logic                   burst,
    input  logic                   two,
    input  logic [QW_BYTES-1:0]    be_lo,
    input  logic [QW_BYTES-1:0]    be_hi,
    input  logic [QW_BYTES*8-1:0]  d_lo,
    input  logic [QW_BYTES*8-1:0]  d_hi,
    output logic                   st_ready,
    output logic                   bus_valid,
    input  logic                   bus_ready,
    output logic [AW-4:0]          bus_qaddr,
    output logic [QW_BYTES-1:0]    bus_be,
    output logic [QW_BYTES*8-1:0]  bus_data,
    output logic [1:0]             bus_beats,
    output logic                   bus_last
);
    localparam int QAW = AW - 3;

    sq_state_e             state;
    logic [QAW-1:0]        r_qaddr;
    logic                  r_burst;
    logic                  r_two;
    logic [QW_BYTES-1:0]   r_be_lo, r_be_hi;
    logic [QW_BYTES*8-1:0] r_d_lo, r_d_hi;
    logic [QAW-1:0]        second_qaddr;
    logic                  start_idx;

    // beat sequencing and capture of the accepted store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            r_qaddr <= '0;
            r_burst <= 1'b0;
            r_two   <= 1'b0;
            r_be_lo <= '0;
            r_be_hi <= '0;
            r_d_lo  <= '0;
            r_d_hi  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        r_qaddr <= addr[AW-1:3];
                        r_burst <= burst;
                        r_two   <= two;
                        r_be_lo <= be_lo;
                        r_be_hi <= be_hi;
                        r_d_lo  <= d_lo;
                        r_d_hi  <= d_hi;
                        state   <= SQ_FIRST;
                    end
                end
                SQ_FIRST:  if (bus_ready) state <= r_two ? SQ_SECOND : SQ_IDLE;
                SQ_SECOND: if (bus_ready) state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    // toggle order for bursts, next qword for split stores
    always_comb begin
        start_idx    = r_qaddr[0];
        second_qaddr = r_burst ? (r_qaddr ^ QAW'(1)) : (r_qaddr + QAW'(1));
    end

    // drive the current beat; toggle bursts pick the qword by start_idx ^ beat
    always_comb begin
        st_ready  = (state == SQ_IDLE);
        bus_valid = (state != SQ_IDLE);
        bus_beats = r_burst ? 2'd2 : 2'd1;
        bus_last  = !(r_burst && state == SQ_FIRST);
        if (state == SQ_SECOND) begin
            bus_qaddr = second_qaddr;
            bus_be    = (r_burst && start_idx) ? r_be_lo : r_be_hi;
            bus_data  = (r_burst && start_idx) ? r_d_lo  : r_d_hi;
        end else begin
            bus_qaddr = r_qaddr;
            bus_be    = (r_burst && start_idx) ? r_be_hi : r_be_lo;
            bus_data  = (r_burst && start_idx) ? r_d_hi  : r_d_lo;
        end
    end

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_qaddr) && $stable(bus_be)
            && $stable(bus_data) && $stable(bus_beats) && $stable(bus_last));

    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !st_ready);

    p_beat_enables_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_be != '0);

    p_burst_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_beats == 2'd2 |-> bus_be == '1);

    p_burst_start_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_beats == 2'd2 && !bus_last |-> bus_qaddr[0] == 1'b0);

    p_last_accept_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_ready && bus_last && bus_beats == 2'd1 && $past(st_ready)
            |=> bus_valid || st_ready);
endmodule

// File: rtl/ucst_splitter.sv
// Top of the uncached store splitter: takes one store per handshake
// and emits qword bus write beats with byte enables.
// Assumes the bus side eventually raises bus_ready.
module ucst_splitter
    import ucst_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_valid,
    output logic                   st_ready,
    input  logic [AW-1:0]          st_addr,
    input  logic [4:0]             st_size,
    input  logic [127:0]           st_data,
    output logic                   st_err,
    output logic                   bus_valid,
    input  logic                   bus_ready,
    output logic [AW-4:0]          bus_qaddr,
    output logic [7:0]             bus_be,
    output logic [63:0]            bus_data,
    output logic [1:0]             bus_beats,
    output logic                   bus_last
);
    logic                  bad, burst, two, accept;
    logic [QW_BYTES-1:0]   be_lo, be_hi;
    logic [QW_BYTES*8-1:0] d_lo, d_hi;

    ucst_decode #(.AW(AW)) u_decode (
        .addr  (st_addr),
        .size  (st_size),
        .data  (st_data),
        .bad   (bad),
        .burst (burst),
        .two   (two),
        .be_lo (be_lo),
        .be_hi (be_hi),
        .d_lo  (d_lo),
        .d_hi  (d_hi)
    );

    // handshake: legal stores start a sequence, illegal ones flag an error
    always_comb begin
        accept = st_valid && st_ready && !bad;
        st_err = st_valid && st_ready && bad;
    end

    ucst_sequencer #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .addr      (st_addr),
        .burst     (burst),
        .two       (two),
        .be_lo     (be_lo),
        .be_hi     (be_hi),
        .d_lo      (d_lo),
        .d_hi      (d_hi),
        .st_ready  (st_ready),
        .bus_valid (bus_valid),
        .bus_ready (bus_ready),
        .bus_qaddr (bus_qaddr),
        .bus_be    (bus_be),
        .bus_data  (bus_data),
        .bus_beats (bus_beats),
        .bus_last  (bus_last)
    );

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |=> !bus_valid);
endmodule

// File: tb/ucst_splitter_tb.sv
`timescale 1ns/1ps
module ucst_splitter_tb;
    localparam int AW  = 16;
    localparam int QAW = AW - 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            st_valid = 1'b0;
    logic            st_ready;
    logic [AW-1:0]   st_addr = '0;
    logic [4:0]      st_size = '0;
    logic [127:0]    st_data = '0;
    logic            st_err;
    logic            bus_valid;
    logic            bus_ready = 1'b0;
    logic [QAW-1:0]  bus_qaddr;
    logic [7:0]      bus_be;
    logic [63:0]     bus_data;
    logic [1:0]      bus_beats;
    logic            bus_last;

    always #2.5 clk = ~clk;

    ucst_splitter #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_size(st_size), .st_data(st_data), .st_err(st_err),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_qaddr(bus_qaddr),
        .bus_be(bus_be), .bus_data(bus_data), .bus_beats(bus_beats), .bus_last(bus_last)
    );

    typedef struct {
        logic [QAW-1:0] qa;
        logic [7:0]     be;
        logic [63:0]    d;
        int             beats;
        bit             last;
        string          req;
    } beat_t;

    typedef struct {
        logic [AW-1:0] a;
        int            sz;
        logic [127:0]  d;
    } st_t;

    beat_t exp_q[$];
    st_t   stim[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    stall_en = 1'b0;
    bit    done     = 1'b0;

    task automatic chk(bit ok, string req, string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic bit is_bad(logic [AW-1:0] a, int sz);
        return !((sz >= 1 && sz <= 8) || (sz == 16 && a[3:0] == 4'h0));
    endfunction

    // reference: build expected beats from the byte-level meaning of a store
    task automatic expand(st_t s);
        beat_t b;
        logic [QAW-1:0] lo;
        logic [7:0]     be2 [2];
        logic [63:0]    d2  [2];
        lo = s.a[AW-1:3];
        if (s.sz == 16) begin
            for (int k = 0; k < 2; k++) begin
                b.qa = lo ^ QAW'(k);
                b.be = 8'hFF;
                b.d = s.d[64*k +: 64];
                b.beats = 2;
                b.last = (k == 1);
                b.req = "R5";
                exp_q.push_back(b);
            end
        end else begin
            be2[0] = '0; be2[1] = '0; d2[0] = '0; d2[1] = '0;
            for (int j = 0; j < s.sz; j++) begin
                logic [AW-1:0] aa;
                int rel;
                int lane;
                aa = s.a + AW'(j);
                rel = (aa[AW-1:3] == lo) ? 0 : 1;
                lane = int'(aa[2:0]);
                be2[rel][lane] = 1'b1;
                d2[rel][lane*8 +: 8] = s.d[j*8 +: 8];
            end
            for (int k = 0; k < 2; k++) begin
                if (be2[k] != 0) begin
                    b.qa = lo + QAW'(k);
                    b.be = be2[k];
                    b.d = d2[k];
                    b.beats = 1;
                    b.last = 1'b1;
                    b.req = (be2[1] != 0) ? "R3/R2" : ((s.sz == 8) ? "R4/R2" : "R1/R2");
                    exp_q.push_back(b);
                end
            end
        end
    endtask

    task automatic add(logic [AW-1:0] a, int sz);
        st_t s;
        s.a = a;
        s.sz = sz;
        s.d = {$urandom, $urandom, $urandom, $urandom};
        stim.push_back(s);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R6", "watchdog expired, run did not finish");
        report();
    end

    initial begin
        logic [QAW-1:0] p_qa;
        logic [7:0]     p_be;
        logic [63:0]    p_d;
        logic [1:0]     p_beats;
        bit             p_last;
        bit             stalled;
        stalled = 1'b0;
        p_qa = '0; p_be = '0; p_d = '0; p_beats = '0; p_last = 1'b0;

        // directed stores: every kind plus the top of the address space
        add(16'h0010, 1);  add(16'h0013, 2);  add(16'h0015, 3);  add(16'h0016, 4);
        add(16'h0018, 8);  add(16'h001F, 2);  add(16'h0021, 8);  add(16'h0030, 16);
        add(16'h0038, 16); add(16'h0040, 0);  add(16'h0040, 9);  add(16'h0044, 17);
        add(16'hFFFC, 8);  add(16'hFFF0, 16); add(16'h0007, 1);  add(16'h0008, 15);
        for (int off = 0; off < 8; off++)
            for (int sz = 1; sz <= 8; sz++)
                add(AW'(16'h0100 + off), sz);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(st_ready === 1'b1 && bus_valid === 1'b0, "R6",
            $sformatf("reset state ready=%b valid=%b expected 1/0", st_ready, bus_valid));

        for (int cyc = 0; cyc < 120000; cyc++) begin
            if (cyc == 1500) begin
                stall_en = 1'b1;
                for (int n = 0; n < 2500; n++) begin
                    int r;
                    logic [AW-1:0] a;
                    r = $urandom % 12;
                    a = AW'($urandom);
                    if (r < 8)       add(a, r + 1);
                    else if (r < 10) add({a[AW-1:4], 4'h0}, 16);
                    else if (r == 10) add(a, 16);
                    else             add(a, 9 + ($urandom % 23));
                end
            end
            if (cyc > 1500 && stim.size() == 0 && exp_q.size() == 0) break;

            // compare outputs against the reference model
            chk(st_ready === (exp_q.size() == 0), "R6",
                $sformatf("st_ready=%b expected %b", st_ready, exp_q.size() == 0));
            chk(bus_valid === (exp_q.size() != 0), "R6/R8",
                $sformatf("bus_valid=%b expected %b", bus_valid, exp_q.size() != 0));
            if (bus_valid === 1'b1 && exp_q.size() != 0) begin
                beat_t e;
                e = exp_q[0];
                chk(bus_qaddr === e.qa && bus_be === e.be && bus_data === e.d &&
                    int'(bus_beats) == e.beats && bus_last === e.last, e.req,
                    $sformatf("qa=%h be=%h d=%h beats=%0d last=%b expected qa=%h be=%h d=%h beats=%0d last=%b",
                              bus_qaddr, bus_be, bus_data, bus_beats, bus_last,
                              e.qa, e.be, e.d, e.beats, e.last));
            end
            if (stalled)
                chk(bus_valid === 1'b1 && bus_qaddr === p_qa && bus_be === p_be &&
                    bus_data === p_d && bus_beats === p_beats && bus_last === p_last, "R7",
                    $sformatf("after stall qa=%h be=%h d=%h expected qa=%h be=%h d=%h",
                              bus_qaddr, bus_be, bus_data, p_qa, p_be, p_d));

            // drive the next cycle's inputs
            bus_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
            st_valid = (stim.size() != 0) && (!stall_en || ($urandom % 4) != 0);
            if (stim.size() != 0) begin
                st_addr = stim[0].a;
                st_size = 5'(stim[0].sz);
                st_data = stim[0].d;
            end
            #1;
            if (st_valid && st_ready === 1'b1) begin
                bit bad;
                bad = is_bad(stim[0].a, stim[0].sz);
                chk(st_err === bad, "R8",
                    $sformatf("st_err=%b expected %b addr=%h size=%0d", st_err, bad,
                              stim[0].a, stim[0].sz));
                if (!bad) expand(stim[0]);
                void'(stim.pop_front());
            end
            stalled = (bus_valid === 1'b1) && !bus_ready;
            p_qa = bus_qaddr; p_be = bus_be; p_d = bus_data;
            p_beats = bus_beats; p_last = bus_last;
            if (bus_valid === 1'b1 && bus_ready && exp_q.size() != 0)
                void'(exp_q.pop_front());
            @(negedge clk);
        end
        chk(stim.size() == 0 && exp_q.size() == 0, "R6",
            $sformatf("left over stores=%0d beats=%0d expected 0/0", stim.size(), exp_q.size()));
        report();
    end
endmodule